// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block reduces a stream of 12-bit readings from up to four sensors into one filtered reading per sensor. Each incoming sample carries a sensor index. The block keeps a running sum, the smallest value and the largest value for each sensor. When a sensor's window is complete, it emits one result and starts a new window for that sensor.

A 3-bit mode field for each sensor selects the filter. Mode 0 passes a single sample through unchanged. Mode 1 averages two samples. Modes 2 to 5 collect 4, 6, 10 or 18 samples. They remove exactly one largest and one smallest value, then average the 2, 4, 8 or 16 samples that are left. Because the count that is left is always a power of two, the division is a right shift.

Top module: `trim_mean_filter`

## Requirements
- R1: While reset is held and in the cycle after it is released, `res_vld` is 0 and `res_val` is 0. Any window that was partly collected before reset is discarded.
- R2: In mode code 0, every sample produces a result equal to that sample.
- R3: In mode code 1, every second sample of a sensor produces floor((a+b)/2).
- R4: Mode codes 2, 3, 4 and 5 close a window after 4, 6, 10 and 18 samples of that sensor. The result is floor((sum − max − min)/K), where K is 2, 4, 8 or 16 respectively.
- R5: `res_vld` pulses for one cycle, in the cycle after the clock edge that accepts the sample closing a window. `res_idx` then holds that sample's sensor index. No pulse follows any other sample.
- R6: The mode of sensor i is read from `mode_cfg[3i+2:3i]`. The fields of other sensors have no effect on sensor i.
- R7: Mode codes 6 and 7 behave exactly like mode code 0.
- R8: Each sensor keeps its own window. Samples of different sensors may be interleaved without changing any sensor's result.
- R9: Eighteen samples of 4095 in mode code 5 give 4095, with no overflow of the accumulator.
- R10: When several samples share the maximum or the minimum value, only one copy of each is removed.
- R11: After a window closes, that sensor's next window starts empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cfg | input | 12 | Four 3-bit mode fields, one per sensor |
| smp_vld | input | 1 | Sample strobe |
| smp_idx | input | 2 | Sensor index of the sample |
| smp_val | input | 12 | Sample value |
| res_vld | output | 1 | Result strobe |
| res_idx | output | 2 | Sensor index of the result |
| res_val | output | 12 | Filtered value |

## Verification
The assertions assume that `mode_cfg` is stable for the whole window of any sensor that has collected samples. They also assume that `smp_idx` is below the sensor count whenever `smp_vld` is high. The bench changes `mode_cfg` only between complete windows or while in reset, and it uses only indices 0 to 3. One directed case deliberately loads a partial window before a reset, so that the discard rule can be checked.

// File: rtl/trim_mean_filter.sv
module trim_mean_filter #(
  parameter int NSENS = 4,
  parameter int SW    = 12,
  parameter int MW    = 3,
  localparam int IW   = (NSENS > 1) ? $clog2(NSENS) : 1,
  localparam int CW   = 5,
  localparam int AW   = SW + CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSENS*MW-1:0] mode_cfg,
  input  logic                smp_vld,
  input  logic [IW-1:0]       smp_idx,
  input  logic [SW-1:0]       smp_val,
  output logic                res_vld,
  output logic [IW-1:0]       res_idx,
  output logic [SW-1:0]       res_val
);

  logic [CW-1:0] cnt_q [NSENS];
  logic [AW-1:0] sum_q [NSENS];
  logic [SW-1:0] lo_q  [NSENS];
  logic [SW-1:0] hi_q  [NSENS];

  logic [MW-1:0] mode_sel;
  logic [CW-1:0] need, cnt_n;
  logic [2:0]    shamt;
  logic          trim, first, last;
  logic [AW-1:0] sum_n, kept, avg;
  logic [SW-1:0] lo_n, hi_n;

  assign mode_sel = mode_cfg[smp_idx*MW +: MW];

  always_comb begin
    case (mode_sel)
      3'd1:    begin need = CW'(2);  shamt = 3'd1; trim = 1'b0; end
      3'd2:    begin need = CW'(4);  shamt = 3'd1; trim = 1'b1; end
      3'd3:    begin need = CW'(6);  shamt = 3'd2; trim = 1'b1; end
      3'd4:    begin need = CW'(10); shamt = 3'd3; trim = 1'b1; end
      3'd5:    begin need = CW'(18); shamt = 3'd4; trim = 1'b1; end
      default: begin need = CW'(1);  shamt = 3'd0; trim = 1'b0; end
    endcase
  end

  assign first = (cnt_q[smp_idx] == '0);
  assign cnt_n = cnt_q[smp_idx] + CW'(1);
  assign last  = (cnt_n >= need);
  assign sum_n = sum_q[smp_idx] + AW'(smp_val);
  assign lo_n  = (first || smp_val < lo_q[smp_idx]) ? smp_val : lo_q[smp_idx];
  assign hi_n  = (first || smp_val > hi_q[smp_idx]) ? smp_val : hi_q[smp_idx];
  assign kept  = trim ? (sum_n - AW'(lo_n) - AW'(hi_n)) : sum_n;
  assign avg   = kept >> shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_idx <= '0;
      res_val <= '0;
      for (int i = 0; i < NSENS; i++) begin
        cnt_q[i] <= '0;
        sum_q[i] <= '0;
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
      end
    end else begin
      res_vld <= 1'b0;
      if (smp_vld) begin
        if (last) begin
          cnt_q[smp_idx] <= '0;
          sum_q[smp_idx] <= '0;
          res_vld <= 1'b1;
          res_idx <= smp_idx;
          res_val <= avg[SW-1:0];
        end else begin
          cnt_q[smp_idx] <= cnt_n;
          sum_q[smp_idx] <= sum_n;
          lo_q[smp_idx]  <= lo_n;
          hi_q[smp_idx]  <= hi_n;
        end
      end
    end
  end

  // R5
  res_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(smp_vld));

  // R5
  res_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> res_idx == $past(smp_idx));

  // R2 R7
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (mode_sel == 3'd0 || mode_sel > 3'd5)) |=> (res_vld && res_val == $past(smp_val)));

  // R11
  generate
    for (genvar g = 0; g < NSENS; g++) begin : g_cnt
      cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[g] < CW'(18));
    end
  endgenerate

endmodule

// File: tb/tb_trim_mean_filter.sv
module tb_trim_mean_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mode_cfg = '0;
  logic        smp_vld = 1'b0;
  logic [1:0]  smp_idx = '0;
  logic [11:0] smp_val = '0;
  logic        res_vld;
  logic [1:0]  res_idx;
  logic [11:0] res_val;

  int total = 0;
  int bad = 0;
  logic        got_v;
  logic [1:0]  got_i;
  logic [11:0] got_x;

  always #2 clk = ~clk;

  trim_mean_filter dut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .smp_vld(smp_vld),
    .smp_idx(smp_idx), .smp_val(smp_val), .res_vld(res_vld),
    .res_idx(res_idx), .res_val(res_val)
  );

  // row: {mode[3], sensor[2], seed[8]}; other sensors' fields are set to 7 (R6)
  localparam logic [12:0] TABLE [10] = '{
    {3'd0, 2'd0, 8'd11}, {3'd1, 2'd1, 8'd23}, {3'd2, 2'd2, 8'd37},
    {3'd3, 2'd3, 8'd41}, {3'd4, 2'd0, 8'd59}, {3'd5, 2'd1, 8'd67},
    {3'd6, 2'd2, 8'd71}, {3'd7, 2'd3, 8'd83}, {3'd5, 2'd1, 8'd97},
    {3'd2, 2'd2, 8'd101}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int idx, input int val);
    smp_vld = 1'b1;
    smp_idx = 2'(idx);
    smp_val = 12'(val);
    @(negedge clk);
    got_v = res_vld;
    got_i = res_idx;
    got_x = res_val;
    smp_vld = 1'b0;
  endtask

  function automatic int need_of(input int m);
    case (m)
      1: return 2;  2: return 4;  3: return 6;  4: return 10;  5: return 18;
      default: return 1;
    endcase
  endfunction

  function automatic int gen(input int seed, input int k);
    return (seed * 37 + k * k * 113 + k * 509) % 4096;
  endfunction

  task automatic window(input int m, input int idx, input int seed, input string req);
    int n = need_of(m);
    int s = 0, lo = 4096, hi = -1, e, v;
    bit early = 0;
    for (int k = 0; k < n; k++) begin
      v = gen(seed, k);
      s += v;
      if (v < lo) lo = v;
      if (v > hi) hi = v;
      send(idx, v);
      if (k < n - 1 && got_v) early = 1;
    end
    if (n == 1) e = s;
    else if (n == 2) e = s / 2;
    else e = (s - lo - hi) / (n - 2);
    chk(!early, "R5 no early strobe", int'(early), 0);
    chk(got_v && got_i == 2'(idx), "R5 strobe/index", int'(got_i), idx);
    chk(got_x == 12'(e), req, int'(got_x), e);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_vld == 1'b0 && res_val == '0, "R1 reset outputs", int'(res_val), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_vld == 1'b0 && res_val == '0, "R1 after release", int'(res_vld), 0);

    for (int r = 0; r < 10; r++) begin
      int m = int'(TABLE[r][12:10]);
      int s = int'(TABLE[r][9:8]);
      mode_cfg = 12'hFFF;
      mode_cfg[s*3 +: 3] = 3'(m);
      window(m, s, int'(TABLE[r][7:0]), "R2 R3 R4 R6 R7 R11 table window");
    end

    // R3 floor
    mode_cfg = {3'd7, 3'd7, 3'd1, 3'd7};
    send(1, 3); send(1, 4);
    chk(got_v && got_x == 12'd3, "R3 floor average", int'(got_x), 3);

    // R8 interleaved sensors
    mode_cfg = {3'd0, 3'd0, 3'd1, 3'd3};
    send(0, 10); send(1, 100); send(0, 50); send(1, 201);
    chk(got_v && got_i == 2'd1 && got_x == 12'd150, "R8 sensor1 result", int'(got_x), 150);
    send(0, 30); send(0, 40); send(0, 20);
    chk(!got_v, "R8 sensor0 still open", int'(got_v), 0);
    send(0, 60);
    chk(got_v && got_i == 2'd0 && got_x == 12'd35, "R8 sensor0 result", int'(got_x), 35);

    // R10 duplicated extremes
    mode_cfg = {3'd0, 3'd2, 3'd3, 3'd0};
    send(2, 7); send(2, 7); send(2, 7); send(2, 3);
    chk(got_v && got_x == 12'd7, "R10 duplicate max", int'(got_x), 7);
    for (int k = 0; k < 5; k++) send(1, 5);
    send(1, 1);
    chk(got_v && got_x == 12'd5, "R10 duplicate min/max", int'(got_x), 5);

    // R9 full scale
    mode_cfg = {3'd5, 3'd0, 3'd0, 3'd0};
    for (int k = 0; k < 18; k++) send(3, 4095);
    chk(got_v && got_x == 12'd4095, "R9 full scale", int'(got_x), 4095);

    // R1 partial window discarded by reset
    mode_cfg = {3'd0, 3'd2, 3'd0, 3'd0};
    send(2, 4000); send(2, 4000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    send(2, 10); send(2, 20); send(2, 30);
    chk(!got_v, "R1 window restarted", int'(got_v), 0);
    send(2, 40);
    chk(got_v && got_x == 12'd25, "R1 fresh window value", int'(got_x), 25);

    // R6 field of another sensor changes nothing for sensor 0
    mode_cfg = {3'd5, 3'd5, 3'd5, 3'd0};
    send(0, 1234);
    chk(got_v && got_x == 12'd1234, "R6 own field only", int'(got_x), 1234);

    @(negedge clk);
    chk(!res_vld, "R5 single-cycle pulse", int'(res_vld), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule